// File: doc/BRIEF.md
# Processor exception entry controller

This block performs the state update a small 32-bit RISC core makes when it enters an exception handler. The pipeline offers a synchronous exception as a valid strobe with a 4-bit cause code. The block also watches two raw interrupt lines: an external device interrupt and a tick-timer interrupt. It picks one request, checks that the cause code is legal and, on that same clock edge, registers everything the handler needs:

- the return address;
- a copy of the status word as it was before entry;
- the fault address, for illegal instructions only;
- the masked status word and power-management word;
- the handler fetch address.

It also produces single-cycle pulses for the core:

- a fetch redirect;
- a clear of the load-linked reservation;
- a clear of the delay-slot flag.

An illegal cause code does not redirect fetch. It raises an error pulse instead.

The status word fields used are:

| Field | Bit |
|---|---|
| supervisor | 0 |
| tick enable | 1 |
| interrupt enable | 2 |
| data-MMU enable | 5 |
| instruction-MMU enable | 6 |
| delay-slot exception | 13 |
| high vector prefix | 14 |

In the power-management word, the doze bit is bit 4 and the sleep bit is bit 5.

The cause codes run from 1 to 14, in this order: reset, bus error, data page fault, instruction page fault, tick (5), alignment, illegal instruction (7), external interrupt (8), data TLB miss, instruction TLB miss, range, system call (12), floating point (13), trap (14).

Top module: `exc_entry_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the status output becomes 0x0001 (supervisor only). All other data outputs become zero and all pulses are low.
- R2: A request with a legal code, taken at an edge, updates every entry register at that edge and raises redirect_o for exactly the following cycle.
- R3: On entry, esr_o gets the pre-entry status input. sr_o gets that status with bits 1, 2, 5 and 6 cleared and bit 0 set; its other bits are unchanged apart from bit 13 (R6).
- R4: On entry, pmr_o gets the power input with bits 4 and 5 cleared, and resv_clr_o pulses together with redirect_o.
- R5: eear_o loads the current PC only on entry with code 7. On every other entry it holds its value.
- R6: With the delay-slot flag set, epc_o = PC-4, status bit 13 is set and dslot_clr_o pulses. Without it, bit 13 is cleared and dslot_clr_o stays low. epc_o = PC+4 for codes 12 and 13, and epc_o = PC for every other code.
- R7: fetch_pc_o = (code << 8), ORed with vbar_i when vbar_en_i is 1, and ORed with 0xF0000000 when status bit 14 is 1.
- R8: The external interrupt (code 8) is taken only if status bit 2 is 1. The tick interrupt (code 5) is taken only if status bit 1 is 1. When both qualify, tick is taken.
- R9: A valid synchronous exception wins over both interrupts in the same cycle.
- R10: A taken request whose code is 0 or 15 pulses unhandled_o for one cycle, gives no redirect and leaves every entry register unchanged.
- R11: In a cycle with no taken request, all registered outputs hold and every pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 16 | Current status word |
| pmr_i | input | 8 | Current power-management word |
| dslot_i | input | 1 | Faulting instruction sits in a delay slot |
| vbar_en_i | input | 1 | Configuration: use vector base |
| vbar_i | input | 32 | Vector base value |
| exc_valid_i | input | 1 | Synchronous exception pending |
| exc_code_i | input | 4 | Cause code of the pending exception |
| ext_irq_i | input | 1 | Raw external interrupt request |
| tick_irq_i | input | 1 | Raw tick-timer interrupt request |
| epc_o | output | 32 | Saved return address |
| esr_o | output | 16 | Saved pre-entry status |
| eear_o | output | 32 | Effective (fault) address |
| sr_o | output | 16 | Status word after entry |
| pmr_o | output | 8 | Power-management word after entry |
| fetch_pc_o | output | 32 | Handler fetch address |
| redirect_o | output | 1 | Fetch redirect pulse |
| resv_clr_o | output | 1 | Reservation invalidate pulse |
| dslot_clr_o | output | 1 | Delay-slot flag clear pulse |
| unhandled_o | output | 1 | Illegal cause code pulse |

## Verification
Arbitration and the return-address adjustment can fall in the same cycle. A synchronous exception of any code may arrive while both interrupt lines are raised and the delay-slot flag is set or clear. Every pass of the cause-code sweep therefore raises both interrupt lines with a random status word. It then judges both parts from the entry registers: the vector must carry the pipeline's code rather than 5 or 8, and the saved PC must still follow the delay-slot and code rule. A second sweep drives only the interrupt lines, across every combination of enables and requests. It checks that the tick interrupt wins over the external one, and that nothing is taken when a line's enable is clear.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  // status word bit positions
  localparam int SR_SM  = 0;
  localparam int SR_TEE = 1;
  localparam int SR_IEE = 2;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_DSX = 13;
  localparam int SR_EPH = 14;
  // power word bit positions
  localparam int PM_DOZE  = 4;
  localparam int PM_SLEEP = 5;

  typedef enum logic [3:0] {
    EC_NONE    = 4'd0,
    EC_RESET   = 4'd1,
    EC_BUSERR  = 4'd2,
    EC_DPAGE   = 4'd3,
    EC_IPAGE   = 4'd4,
    EC_TICK    = 4'd5,
    EC_ALIGN   = 4'd6,
    EC_ILLEGAL = 4'd7,
    EC_EXTINT  = 4'd8,
    EC_DTLB    = 4'd9,
    EC_ITLB    = 4'd10,
    EC_RANGE   = 4'd11,
    EC_SYSCALL = 4'd12,
    EC_FPU     = 4'd13,
    EC_TRAP    = 4'd14
  } exc_code_e;

  localparam int EC_LAST = 14;
endpackage

// File: rtl/exc_int_arbiter.sv
module exc_int_arbiter
  import exc_entry_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              ext_irq_i,
  input  logic              tick_irq_i,
  input  logic              iee_i,
  input  logic              tee_i,
  output logic              take_o,
  output logic              legal_o,
  output logic [CODE_W-1:0] code_o
);
  logic ext_ok, tick_ok;
  assign ext_ok  = ext_irq_i && iee_i;
  assign tick_ok = tick_irq_i && tee_i;

  // pipeline exception first, then tick, then external interrupt
  always_comb begin
    code_o = '0;
    take_o = 1'b1;
    if (exc_valid_i)  code_o = exc_code_i;
    else if (tick_ok) code_o = CODE_W'(EC_TICK);
    else if (ext_ok)  code_o = CODE_W'(EC_EXTINT);
    else              take_o = 1'b0;
  end

  assign legal_o = (code_o != '0) && (int'(code_o) <= EC_LAST);
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SR_W   = 16,
  parameter int PMR_W  = 8,
  parameter int CODE_W = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [SR_W-1:0]   sr_i,
  input  logic [PMR_W-1:0]  pmr_i,
  input  logic              dslot_i,
  input  logic              vbar_en_i,
  input  logic [ADDR_W-1:0] vbar_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [ADDR_W-1:0] ret_pc_o,
  output logic [SR_W-1:0]   new_sr_o,
  output logic [PMR_W-1:0]  new_pmr_o,
  output logic [ADDR_W-1:0] vector_o
);
  localparam int VEC_SH = 8;
  localparam logic [ADDR_W-1:0] HI_PREFIX = {4'hF, {(ADDR_W-4){1'b0}}};

  function automatic logic [ADDR_W-1:0] f_ret_pc(input logic [ADDR_W-1:0] pc,
                                                 input logic ds,
                                                 input logic [CODE_W-1:0] c);
    if (ds) return pc - ADDR_W'(4);
    if (c == CODE_W'(EC_SYSCALL) || c == CODE_W'(EC_FPU)) return pc + ADDR_W'(4);
    return pc;
  endfunction

  function automatic logic [SR_W-1:0] f_entry_sr(input logic [SR_W-1:0] s,
                                                 input logic ds);
    logic [SR_W-1:0] r;
    r = s;
    r[SR_DME] = 1'b0;
    r[SR_IME] = 1'b0;
    r[SR_IEE] = 1'b0;
    r[SR_TEE] = 1'b0;
    r[SR_SM]  = 1'b1;
    r[SR_DSX] = ds;
    return r;
  endfunction

  function automatic logic [PMR_W-1:0] f_entry_pmr(input logic [PMR_W-1:0] p);
    logic [PMR_W-1:0] r;
    r = p;
    r[PM_DOZE]  = 1'b0;
    r[PM_SLEEP] = 1'b0;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] f_vector(input logic [CODE_W-1:0] c,
                                                 input logic use_base,
                                                 input logic [ADDR_W-1:0] base,
                                                 input logic hi);
    logic [ADDR_W-1:0] v;
    v = ADDR_W'(c) << VEC_SH;
    if (use_base) v = v | base;
    if (hi) v = v | HI_PREFIX;
    return v;
  endfunction

  assign ret_pc_o  = f_ret_pc(pc_i, dslot_i, code_i);
  assign new_sr_o  = f_entry_sr(sr_i, dslot_i);
  assign new_pmr_o = f_entry_pmr(pmr_i);
  assign vector_o  = f_vector(code_i, vbar_en_i, vbar_i, sr_i[SR_EPH]);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SR_W   = 16,
  parameter int PMR_W  = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [SR_W-1:0]   sr_i,
  input  logic [PMR_W-1:0]  pmr_i,
  input  logic              dslot_i,
  input  logic              vbar_en_i,
  input  logic [ADDR_W-1:0] vbar_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              ext_irq_i,
  input  logic              tick_irq_i,
  output logic [ADDR_W-1:0] epc_o,
  output logic [SR_W-1:0]   esr_o,
  output logic [ADDR_W-1:0] eear_o,
  output logic [SR_W-1:0]   sr_o,
  output logic [PMR_W-1:0]  pmr_o,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic              redirect_o,
  output logic              resv_clr_o,
  output logic              dslot_clr_o,
  output logic              unhandled_o
);
  localparam logic [SR_W-1:0] SR_RESET = SR_W'(1) << SR_SM;

  // named internal events
  logic              take_w, legal_w, enter_w, reject_w;
  logic [CODE_W-1:0] code_w;
  logic [ADDR_W-1:0] ret_pc_w, vector_w;
  logic [SR_W-1:0]   new_sr_w;
  logic [PMR_W-1:0]  new_pmr_w;

  exc_int_arbiter #(.CODE_W(CODE_W)) u_arb (
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .ext_irq_i   (ext_irq_i),
    .tick_irq_i  (tick_irq_i),
    .iee_i       (sr_i[SR_IEE]),
    .tee_i       (sr_i[SR_TEE]),
    .take_o      (take_w),
    .legal_o     (legal_w),
    .code_o      (code_w)
  );

  exc_entry_calc #(.ADDR_W(ADDR_W), .SR_W(SR_W), .PMR_W(PMR_W), .CODE_W(CODE_W)) u_calc (
    .pc_i      (pc_i),
    .sr_i      (sr_i),
    .pmr_i     (pmr_i),
    .dslot_i   (dslot_i),
    .vbar_en_i (vbar_en_i),
    .vbar_i    (vbar_i),
    .code_i    (code_w),
    .ret_pc_o  (ret_pc_w),
    .new_sr_o  (new_sr_w),
    .new_pmr_o (new_pmr_w),
    .vector_o  (vector_w)
  );

  assign enter_w  = take_w && legal_w;
  assign reject_w = take_w && !legal_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_o       <= '0;
      esr_o       <= '0;
      eear_o      <= '0;
      sr_o        <= SR_RESET;
      pmr_o       <= '0;
      fetch_pc_o  <= '0;
      redirect_o  <= 1'b0;
      resv_clr_o  <= 1'b0;
      dslot_clr_o <= 1'b0;
      unhandled_o <= 1'b0;
    end else begin
      redirect_o  <= enter_w;
      resv_clr_o  <= enter_w;
      dslot_clr_o <= enter_w && dslot_i;
      unhandled_o <= reject_w;
      if (enter_w) begin
        epc_o      <= ret_pc_w;
        esr_o      <= sr_i;
        sr_o       <= new_sr_w;
        pmr_o      <= new_pmr_w;
        fetch_pc_o <= vector_w;
        if (code_w == CODE_W'(EC_ILLEGAL)) eear_o <= pc_i;
      end
    end
  end

  // assertions
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !take_w |=> ($stable(epc_o) && $stable(sr_o) && $stable(fetch_pc_o) && !redirect_o));
  assert_entry_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (sr_o[SR_SM] && !sr_o[SR_IEE] && !sr_o[SR_TEE] && !sr_o[SR_DME] && !sr_o[SR_IME]));
  assert_resv_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> resv_clr_o);
  assert_dsx_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dslot_clr_o |-> sr_o[SR_DSX]);
  assert_tick_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid_i && tick_irq_i && ext_irq_i && sr_i[SR_TEE] && sr_i[SR_IEE]) |-> code_w == CODE_W'(EC_TICK));
  assert_sync_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i |-> (take_w && code_w == exc_code_i));
  assert_no_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect_o && unhandled_o));
  assert_reject_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reject_w |=> ($stable(epc_o) && $stable(eear_o) && unhandled_o));
endmodule

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0, vbar_i = '0;
  logic [15:0] sr_i = '0;
  logic [7:0]  pmr_i = '0;
  logic        dslot_i = 1'b0, vbar_en_i = 1'b0, exc_valid_i = 1'b0;
  logic [3:0]  exc_code_i = '0;
  logic        ext_irq_i = 1'b0, tick_irq_i = 1'b0;
  logic [31:0] epc_o, eear_o, fetch_pc_o;
  logic [15:0] esr_o, sr_o;
  logic [7:0]  pmr_o;
  logic        redirect_o, resv_clr_o, dslot_clr_o, unhandled_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] lcg = 32'h1234_5678;

  // expected held state
  logic [31:0] x_epc, x_eear, x_vec;
  logic [15:0] x_esr, x_sr;
  logic [7:0]  x_pmr;

  always #2 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .sr_i(sr_i), .pmr_i(pmr_i),
    .dslot_i(dslot_i), .vbar_en_i(vbar_en_i), .vbar_i(vbar_i),
    .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
    .ext_irq_i(ext_irq_i), .tick_irq_i(tick_irq_i),
    .epc_o(epc_o), .esr_o(esr_o), .eear_o(eear_o), .sr_o(sr_o), .pmr_o(pmr_o),
    .fetch_pc_o(fetch_pc_o), .redirect_o(redirect_o), .resv_clr_o(resv_clr_o),
    .dslot_clr_o(dslot_clr_o), .unhandled_o(unhandled_o)
  );

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic rd, input logic dc, input logic un);
    chk({req, " epc"}, epc_o, x_epc);
    chk({req, " esr"}, 32'(esr_o), 32'(x_esr));
    chk({req, " eear R5"}, eear_o, x_eear);
    chk({req, " sr R3"}, 32'(sr_o), 32'(x_sr));
    chk({req, " pmr R4"}, 32'(pmr_o), 32'(x_pmr));
    chk({req, " vector R7"}, fetch_pc_o, x_vec);
    chk({req, " redirect R2"}, 32'(redirect_o), 32'(rd));
    chk({req, " resv R4"}, 32'(resv_clr_o), 32'(rd));
    chk({req, " dslot_clr R6"}, 32'(dslot_clr_o), 32'(dc));
    chk({req, " unhandled R10"}, 32'(unhandled_o), 32'(un));
  endtask

  // one request cycle, then one idle cycle
  task automatic run(input string req, input logic [31:0] pc, input logic [15:0] sr,
                     input logic [7:0] pmr, input logic ds, input logic vbe,
                     input logic [31:0] vb, input logic ev, input logic [3:0] code,
                     input logic ext, input logic tim);
    logic take;
    int c;
    take = 1'b1;
    c = 0;
    if (ev) c = int'(code);
    else if (tim && sr[1]) c = 5;
    else if (ext && sr[2]) c = 8;
    else take = 1'b0;
    pc_i = pc; sr_i = sr; pmr_i = pmr; dslot_i = ds; vbar_en_i = vbe; vbar_i = vb;
    exc_valid_i = ev; exc_code_i = code; ext_irq_i = ext; tick_irq_i = tim;
    @(negedge clk);
    if (take && c >= 1 && c <= 14) begin
      x_epc = ds ? pc - 32'd4 : ((c == 12 || c == 13) ? pc + 32'd4 : pc);
      x_esr = sr;
      x_sr  = (sr & ~16'h2066) | 16'h0001 | (ds ? 16'h2000 : 16'h0000);
      x_pmr = pmr & ~8'h30;
      if (c == 7) x_eear = pc;
      x_vec = (32'(c) * 32'd256) | (vbe ? vb : 32'd0) | (sr[14] ? 32'hF000_0000 : 32'd0);
      check_all(req, 1'b1, ds, 1'b0);
    end else if (take) begin
      check_all(req, 1'b0, 1'b0, 1'b1);
    end else begin
      check_all(req, 1'b0, 1'b0, 1'b0);
    end
    exc_valid_i = 1'b0; ext_irq_i = 1'b0; tick_irq_i = 1'b0;
    pc_i = next_rand(); sr_i = 16'(next_rand()) & ~16'h0006;
    @(negedge clk);
    check_all("R11 idle", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    x_epc = '0; x_esr = '0; x_eear = '0; x_sr = 16'h0001; x_pmr = '0; x_vec = '0;
    check_all("R1 reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release", 1'b0, 1'b0, 1'b0);

    // R2 R5 R6 R7 R9 R10: every code with both interrupts raised
    for (int c = 0; c < 16; c++)
      for (int ds = 0; ds < 2; ds++)
        for (int vbe = 0; vbe < 2; vbe++)
          for (int eph = 0; eph < 2; eph++) begin
            logic [31:0] pc;
            logic [15:0] sr;
            pc = (c == 0 && ds == 1) ? 32'd0 : next_rand();
            if (c == 14 && ds == 0) pc = 32'hFFFF_FFFC;
            sr = (16'(next_rand()) & ~16'h4000) | (eph != 0 ? 16'h4000 : 16'h0000);
            run("R9 sync", pc, sr, 8'(next_rand()), ds[0], vbe[0],
                next_rand() & 32'hFFFF_E000, 1'b1, 4'(c), 1'b1, 1'b1);
          end

    // R8 interrupt arbitration and enables
    for (int m = 0; m < 32; m++) begin
      logic [15:0] sr;
      sr = (16'(next_rand()) & ~16'h0006) | (m[0] ? 16'h0002 : 16'h0) | (m[1] ? 16'h0004 : 16'h0);
      run("R8 irq", next_rand(), sr, 8'hFF, m[4], m[2], 32'h0001_0000,
          1'b0, 4'(next_rand()), m[2], m[3]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule